// File: doc/BRIEF.md
# I2C SCL Timing Divider Generator

This block derives the serial clock for an I2C controller from the system clock. The caller supplies a divider ratio: the system clock frequency divided by the wanted bus rate. An encoder splits that ratio into a base clock exponent N and two 4-bit phase counts, one for the low phase and one for the high phase. The three values are also packed into a 32-bit timing word that the configuration logic can read back. A prescaler produces a base tick once every 2^N system clocks, and a phase sequencer counts those ticks to drive SCL low and then release it.

While the block is enabled it runs low and high phases back to back. When a target holds the line low after the controller has released it, the high phase stops counting. A change of ratio while the block runs takes effect only at the start of the next low phase, so no SCL period is ever cut short. The block also reports when the requested ratio needs the high-speed mode, which has one-cycle SDA drive. The `scl_in` input must already be synchronised to `clk`.

Top module: `scl_timing_gen`

## Requirements
- R1: The encoder starts from the ratio and halves it repeatedly while the value is 16 or more. The exponent N in `timing_word[3:0]` is the number of halvings.
- R2: If any bit dropped during the halvings was 1, the remaining ratio is raised by one, which rounds the bus rate down.
- R3: With remaining ratio M, the low count is (M>>1)-1 and sits in `timing_word[15:12]`. The high count is M-low-2 and sits in `timing_word[19:16]`.
- R4: All other bits of `timing_word` hold the fixed pattern 0x77700300 (bits 31:20 = 0x777, bits 11:4 = 0x30).
- R5: `hs_mode` is 1 exactly when the ratio is below HS_RATIO, which is 625 by default (a bus rate above 400 kHz at a 250 MHz clock).
- R6: A ratio of 0 or 1 is treated as 2, which gives a low count of 0 and a high count of 0.
- R7: Each low phase drives `scl_low` for (low+1)*2^N clock cycles.
- R8: Each high phase releases `scl_low` for (high+1)*2^N clock cycles when no target stretches the clock.
- R9: While `scl_low` is 0 in a high phase and `scl_in` reads 0, the high phase makes no progress. The phase is longer by exactly the number of stretched cycles.
- R10: A ratio changed during a period does not alter that period. The new low and high counts apply from the next low phase.
- R11: In reset, and in the cycle after `en` is seen low, `scl_low` and `base_tick` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Run the SCL generator |
| ratio | input | RATIO_W | Requested divider ratio, system clock / bus rate |
| scl_in | input | 1 | Sensed SCL line level, already synchronised |
| scl_low | output | 1 | 1 = pull SCL low, 0 = release |
| base_tick | output | 1 | One-cycle pulse every 2^N clocks while running |
| timing_word | output | 32 | Packed encoding of the current ratio |
| hs_mode | output | 1 | Ratio needs the high-speed mode |

## Verification
The assertions check three rules on every cycle. SCL is released after enable drops. A low phase ends only on a base tick. A stretched high phase never moves on to low. A further check confirms that the encoded high count never falls below the low count. The exact number of cycles in each phase cannot be checked per cycle, nor can the rounding of odd ratios, the added length from a stretch, or the rule that a ratio change waits for the next low phase. The bench's scoreboard scenarios show these by measuring whole low and high runs against expected lengths.

// File: rtl/scl_timing_pkg.sv
// Shared types and constants for the SCL timing divider generator.
// Assumes the phase counts are 4 bits and the exponent field is 4 bits.
package scl_timing_pkg;

    localparam int PHASE_W = 4;
    localparam int EXP_W   = 4;
    localparam int WORD_W  = 32;

    // Fixed pattern in the fields of the timing word that are not computed
    localparam logic [WORD_W-1:0] FIXED_FIELDS = 32'h7770_0300;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } scl_phase_e;

    typedef struct packed {
        logic [EXP_W-1:0]   exp_n;
        logic [PHASE_W-1:0] low_cnt;
        logic [PHASE_W-1:0] high_cnt;
    } scl_cfg_t;

endpackage

// File: rtl/scl_ratio_encoder.sv
// Combinational encoder: turns a divider ratio into an exponent and two
// phase counts, packs them into the timing word and flags high-speed mode.
// Assumes RATIO_W - 4 <= 15 so the exponent fits its 4-bit field.
module scl_ratio_encoder
    import scl_timing_pkg::*;
#(
    parameter int RATIO_W  = 16,
    parameter int HS_RATIO = 625
) (
    input  logic [RATIO_W-1:0] ratio,
    output scl_cfg_t           cfg,
    output logic [WORD_W-1:0]  word,
    output logic               hs
);
    localparam int MAX_N = RATIO_W - 4;

    logic [RATIO_W-1:0] r;
    logic               sticky;
    logic [EXP_W-1:0]   n;
    logic [4:0]         rem;
    logic [4:0]         lo5;
    logic [4:0]         hi5;

    // Halve the ratio until it fits 4 bits, tracking lost ones, then split it
    always_comb begin
        r      = (ratio < RATIO_W'(2)) ? RATIO_W'(2) : ratio;
        sticky = 1'b0;
        n      = '0;
        for (int i = 0; i < MAX_N; i++) begin
            if (r >= RATIO_W'(16)) begin
                sticky = sticky | r[0];
                r      = r >> 1;
                n      = n + EXP_W'(1);
            end
        end
        rem = {1'b0, r[3:0]} + {4'd0, sticky};
        lo5 = (rem >> 1) - 5'd1;
        hi5 = rem - lo5 - 5'd2;
    end

    // Pack the fields and compare against the high-speed threshold
    always_comb begin
        cfg.exp_n    = n;
        cfg.low_cnt  = lo5[PHASE_W-1:0];
        cfg.high_cnt = hi5[PHASE_W-1:0];
        word = FIXED_FIELDS | {12'd0, hi5[3:0], lo5[3:0], 8'd0, n};
        hs   = (ratio < RATIO_W'(HS_RATIO));
    end

endmodule

// File: rtl/scl_base_prescaler.sv
// Base tick prescaler: while run is high, pulses tick once every 2^exp_n
// clocks. The count restarts from zero whenever run is low.
// Assumes exp_n <= MAX_N.
module scl_base_prescaler
    import scl_timing_pkg::*;
#(
    parameter int MAX_N = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [EXP_W-1:0] exp_n,
    output logic             tick
);
    logic [MAX_N-1:0] cnt;
    logic [MAX_N:0]   span;
    logic [MAX_N-1:0] term;

    // Terminal count is 2^exp_n - 1
    always_comb begin
        span = ((MAX_N+1)'(1) << exp_n) - (MAX_N+1)'(1);
        term = span[MAX_N-1:0];
        tick = run && (cnt == term);
    end

    // Count clocks toward the terminal value, clearing on tick or pause
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + MAX_N'(1);
        end
    end

endmodule

// File: rtl/scl_phase_sequencer.sv
// Phase sequencer: alternates SCL low and high phases, counting base ticks.
// It latches a new configuration only when a low phase begins, and it holds
// the high phase while the sensed line is still low (clock stretching).
module scl_phase_sequencer
    import scl_timing_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             scl_in,
    input  logic             tick,
    input  scl_cfg_t         next_cfg,
    output logic [EXP_W-1:0] exp_n,
    output logic             run,
    output logic             scl_low
);
    scl_phase_e         phase;
    scl_cfg_t           cur;
    logic [PHASE_W-1:0] ph_cnt;
    logic               stretch;

    // Derive the pause condition and the drive level from the phase
    always_comb begin
        stretch = (phase == PH_HIGH) && !scl_in;
        run     = (phase != PH_IDLE) && !stretch;
        scl_low = (phase == PH_LOW);
        exp_n   = cur.exp_n;
    end

    // Step through the phases on base ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            cur    <= '0;
            ph_cnt <= '0;
        end else if (!en) begin
            phase  <= PH_IDLE;
            ph_cnt <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    phase  <= PH_LOW;
                    cur    <= next_cfg;
                    ph_cnt <= '0;
                end
                PH_LOW: begin
                    if (tick) begin
                        if (ph_cnt == cur.low_cnt) begin
                            phase  <= PH_HIGH;
                            ph_cnt <= '0;
                        end else begin
                            ph_cnt <= ph_cnt + PHASE_W'(1);
                        end
                    end
                end
                PH_HIGH: begin
                    if (tick) begin
                        if (ph_cnt == cur.high_cnt) begin
                            phase  <= PH_LOW;
                            cur    <= next_cfg;
                            ph_cnt <= '0;
                        end else begin
                            ph_cnt <= ph_cnt + PHASE_W'(1);
                        end
                    end
                end
                default: begin
                    phase  <= PH_IDLE;
                    ph_cnt <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/scl_timing_gen.sv
// Top of the SCL timing divider generator. It encodes the ratio, scales the
// system clock to base ticks and sequences the SCL phases.
// Assumes scl_in is already synchronised to clk.
module scl_timing_gen
    import scl_timing_pkg::*;
#(
    parameter int RATIO_W  = 16,
    parameter int CLK_HZ   = 250_000_000,
    parameter int FAST_HZ  = 400_000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [RATIO_W-1:0] ratio,
    input  logic               scl_in,
    output logic               scl_low,
    output logic               base_tick,
    output logic [WORD_W-1:0]  timing_word,
    output logic               hs_mode
);
    localparam int MAX_N    = RATIO_W - 4;
    localparam int HS_RATIO = CLK_HZ / FAST_HZ;

    scl_cfg_t         enc_cfg;
    logic [EXP_W-1:0] exp_n;
    logic             run;

    scl_ratio_encoder #(
        .RATIO_W  (RATIO_W),
        .HS_RATIO (HS_RATIO)
    ) u_enc (
        .ratio (ratio),
        .cfg   (enc_cfg),
        .word  (timing_word),
        .hs    (hs_mode)
    );

    scl_base_prescaler #(
        .MAX_N (MAX_N)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .exp_n (exp_n),
        .tick  (base_tick)
    );

    scl_phase_sequencer u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .scl_in   (scl_in),
        .tick     (base_tick),
        .next_cfg (enc_cfg),
        .exp_n    (exp_n),
        .run      (run),
        .scl_low  (scl_low)
    );

endmodule

// File: rtl/scl_timing_checker.sv
// Checker for the SCL timing divider generator, bound to the top module.
module scl_timing_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        en,
    input logic        scl_in,
    input logic        scl_low,
    input logic        base_tick,
    input logic [31:0] timing_word
);

    AST_RELEASE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!scl_low && !base_tick)); // R11

    AST_LOW_ENDS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(scl_low) && $past(en)) |-> $past(base_tick)); // R7

    AST_STRETCH_HOLDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && !scl_low && !scl_in) |=> (!en || !scl_low)); // R9

    // Check that the encoded high count never falls below the low count
    always @(posedge clk) begin
        if (rst_n) begin
            AST_HIGH_NOT_BELOW_LOW: assert (timing_word[19:16] >= timing_word[15:12]); // R3
        end
    end

endmodule

bind scl_timing_gen scl_timing_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .scl_in      (scl_in),
    .scl_low     (scl_low),
    .base_tick   (base_tick),
    .timing_word (timing_word)
);

// File: tb/tb_scl_timing_gen.sv
`timescale 1ns/1ps
module tb_scl_timing_gen;

    typedef struct {
        int    lo_len;
        int    hi_len;
        string tag;
    } pair_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [15:0] ratio = 16'd10;
    logic        scl_in;
    logic        scl_low;
    logic        base_tick;
    logic [31:0] timing_word;
    logic        hs_mode;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    int    pops = 0;
    int    req_stretch = 0;
    int    stretch_left = 0;
    pair_t expq[$];

    always #2 clk = ~clk;

    scl_timing_gen dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .ratio       (ratio),
        .scl_in      (scl_in),
        .scl_low     (scl_low),
        .base_tick   (base_tick),
        .timing_word (timing_word),
        .hs_mode     (hs_mode)
    );

    // Open-drain line model with a target that stretches each high phase
    assign scl_in = !scl_low && (stretch_left == 0);
    always @(posedge clk) begin
        if (scl_low) stretch_left <= req_stretch;
        else if (stretch_left > 0) stretch_left <= stretch_left - 1;
    end

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Monitor: measure low/high runs and compare with the scoreboard queue
    int  low_len = 0, high_len = 0, low_saved = 0;
    bit  prev_low = 0, have_low = 0;
    always @(negedge clk) begin
        if (!rst_n || !en) begin
            prev_low = 0; have_low = 0; low_len = 0; high_len = 0;
        end else begin
            if (scl_low) begin
                if (!prev_low) begin
                    if (have_low && expq.size() > 0) begin
                        pair_t e;
                        e = expq.pop_front();
                        pops++;
                        checks += 2;
                        if (low_saved != e.lo_len) begin
                            errors++;
                            $display("FAIL %s low run: got %0d expected %0d", e.tag, low_saved, e.lo_len);
                        end
                        if (high_len != e.hi_len) begin
                            errors++;
                            $display("FAIL %s high run: got %0d expected %0d", e.tag, high_len, e.hi_len);
                        end
                    end
                    low_len = 1; have_low = 0;
                end else low_len++;
            end else begin
                if (prev_low) begin
                    low_saved = low_len; have_low = 1; high_len = 1;
                end else high_len++;
            end
            prev_low = scl_low;
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic word_case(input logic [15:0] r, input logic [31:0] exp, input string tag);
        @(negedge clk);
        ratio = r;
        #1;
        check(tag, timing_word, exp);
    endtask

    task automatic push(input int lo, input int hi, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            pair_t p;
            p.lo_len = lo; p.hi_len = hi; p.tag = tag;
            expq.push_back(p);
        end
    endtask

    task automatic drain_and_stop();
        while (expq.size() > 0) @(negedge clk);
        @(negedge clk);
        en = 1'b0;
        repeat (3) @(negedge clk);
        check("R11 idle scl_low", {31'd0, scl_low}, 32'd0);
        check("R11 idle tick", {31'd0, base_tick}, 32'd0);
    endtask

    task automatic run_case(input logic [15:0] r, input int s, input int lo, input int hi,
                            input int n, input string tag);
        @(negedge clk);
        ratio = r; req_stretch = s;
        push(lo, hi, n, tag);
        en = 1'b1;
        drain_and_stop();
        req_stretch = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R11 reset scl_low", {31'd0, scl_low}, 32'd0);
        check("R11 reset tick", {31'd0, base_tick}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Encoding
        word_case(16'd100, 32'h7776_5303, "R1 R2 R3 ratio 100");
        word_case(16'd10, 32'h7774_4300, "R3 ratio 10");
        check("R4 fixed fields", timing_word & 32'hFFF0_0FF0, 32'h7770_0300);
        word_case(16'd16, 32'h7773_3301, "R1 ratio 16");
        word_case(16'd17, 32'h7774_3301, "R2 ratio 17");
        word_case(16'd31, 32'h7777_7301, "R2 ratio 31");
        word_case(16'hFFFF, 32'h7777_730C, "R1 ratio max");
        word_case(16'd1, 32'h7770_0300, "R6 ratio 1");
        word_case(16'd0, 32'h7770_0300, "R6 ratio 0");
        word_case(16'd624, 32'h7774_4306, "R1 ratio 624");
        check("R5 hs at 624", {31'd0, hs_mode}, 32'd1);
        word_case(16'd625, 32'h7774_4306, "R2 ratio 625");
        check("R5 no hs at 625", {31'd0, hs_mode}, 32'd0);
        check("R11 no tick while off", {31'd0, base_tick}, 32'd0);

        // Phase timing
        run_case(16'd10, 0, 5, 5, 3, "R7 R8 ratio 10");
        run_case(16'd100, 0, 48, 56, 2, "R7 R8 ratio 100");
        run_case(16'd17, 0, 8, 10, 2, "R2 R8 ratio 17");
        run_case(16'd1, 0, 1, 1, 2, "R6 clamp");
        run_case(16'd10, 7, 5, 12, 2, "R9 stretch N0");
        run_case(16'd100, 5, 48, 61, 1, "R9 stretch N3");

        // Ratio change mid-run waits for the next low phase
        begin
            int base;
            @(negedge clk);
            ratio = 16'd10;
            push(5, 5, 2, "R10 old ratio");
            push(48, 56, 2, "R10 new ratio");
            base = pops;
            en = 1'b1;
            while (pops < base + 1) @(negedge clk);
            @(negedge clk);
            ratio = 16'd100;
            drain_and_stop();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule